// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog that software services through a small register file on a simple synchronous bus. A prescaler divides the clock into a fixed tick. The counter loses one count per tick and starts from the programmed timeout. If software does not service the timer, the first expiry sets a status flag and, when enabled, pulses an interrupt request. The counter then reloads by itself and runs a second period. If that period also expires without service, the block raises a reset request for four clocks. A no-reboot control suppresses that request.

Software services the timer by writing any value to the reload address. A halt control freezes the count. Status flags are cleared by writing ones. A lock input pins the no-reboot control on, so that software cannot arm the reset path.

Register map (byte 0 holds every control and status field):

- address 0: the timeout register.
- address 1: the reload register.
- address 2: the control register. Bit 0 is halt, bit 1 is the interrupt enable, bit 2 is no-reboot.
- address 3: the status register. Bit 0 is first timeout, bit 1 is second timeout, bit 2 is the boot flag.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the control register reads 0x1 (halted, interrupt off, no-reboot off). Status reads 0. The timeout field reads its maximum (0x3FF when WIDE=1). `irq` and `rst_req` are low.
- R2: The timeout field sits in bits 9:0 of the 16-bit register at address 0. With WIDE=0 it sits in bits 5:0 of an 8-bit register. The upper reserved bits read 0 and writes never change them. Only bytes whose byte enable is 1 are written.
- R3: A programmed timeout below 2 is used as 2 ticks.
- R4: One tick lasts PRESCALE clocks. After a reload write in cycle c, the first expiry becomes visible in cycle c+1+PRESCALE*T, where T is the effective timeout. That expiry sets status bit 0. `irq` is high for exactly that one cycle, and only if control bit 1 is 1.
- R5: The counter reloads itself at the first expiry. A second expiry with no reload write in between sets status bit 1 and status bit 2 (boot). It also drives `rst_req` high for exactly 4 cycles.
- R6: A write to address 1 with any data and any byte enables restarts the count from the effective timeout. It also restarts the prescaler and returns the timer to its first stage.
- R7: While control bit 0 is 1, the counter and prescaler hold. When the bit clears, the count resumes from the held value.
- R8: Writing 1 to a status bit clears that bit. Writing 0 leaves it unchanged. Each bit clears independently.
- R9: With control bit 2 set, a second expiry still sets status bit 1. It does not set status bit 2 and `rst_req` stays low.
- R10: While `nrb_lock` is 1, control bit 2 reads 1 and is stored as 1. A write of 0 cannot clear it until the lock drops.
- R11: If a reload write lands in the cycle of an expiry, the reload wins. No status flag is set and no `irq` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW (16 or 8) | Write data |
| bus_we | input | 1 | Write strobe |
| bus_be | input | DW/8 | Byte enables |
| bus_rdata | output | DW | Read data, combinational from `bus_addr` |
| nrb_lock | input | 1 | Forces no-reboot on while high |
| irq | output | 1 | One-cycle interrupt on first expiry |
| rst_req | output | 1 | Four-cycle reset request on second expiry |

## Verification
Register writes are visible on `bus_rdata` one cycle after the write cycle. A first expiry appears PRESCALE*T+1 cycles after the reload write cycle, and a second expiry appears 2*PRESCALE*T+1 cycles after it. `rst_req` then stays high for that cycle and the three cycles that follow.

The bench stamps every expected result with the absolute cycle in which it is due. It checks both edges of each event: the flag still clear one cycle before, and set in its cycle. The reload-priority case drives the reload write in the exact cycle of the expiry edge.

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter bit WIDE     = 1'b1,
  parameter int PRESCALE = 1000,
  parameter int AW       = 2,
  localparam int DW      = WIDE ? 16 : 8,
  localparam int FW      = WIDE ? 10 : 6,
  localparam int BEW     = DW / 8,
  localparam int PW      = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic [BEW-1:0] bus_be,
  output logic [DW-1:0] bus_rdata,
  input  logic          nrb_lock,
  output logic          irq,
  output logic          rst_req
);
  localparam logic [FW-1:0] FMAX = {FW{1'b1}};
  localparam logic [DW-1:0] FMASK = DW'(FMAX);

  logic [DW-1:0] tmo_q, bmask, wmask;
  logic [FW-1:0] cnt_q, eff;
  logic [PW-1:0] pre_q;
  logic [2:0]    rcnt_q;
  logic halt_q, ien_q, nrb_q, stage_q, irq_q;
  logic sts_to_q, sts_2nd_q, sts_boot_q;

  wire wr_tmo = bus_we && bus_addr == AW'(0);
  wire wr_rld = bus_we && bus_addr == AW'(1);
  wire wr_ctl = bus_we && bus_addr == AW'(2) && bus_be[0];
  wire wr_sts = bus_we && bus_addr == AW'(3) && bus_be[0];
  wire nrb_eff = nrb_q | nrb_lock;
  wire tick   = !halt_q && pre_q == PW'(PRESCALE - 1);
  wire expire = tick && !wr_rld && cnt_q <= FW'(1);
  wire exp1   = expire && !stage_q;
  wire exp2   = expire && stage_q;
  wire fire   = exp2 && !nrb_eff;

  assign eff = (tmo_q[FW-1:0] < FW'(2)) ? FW'(2) : tmo_q[FW-1:0];
  assign irq = irq_q;
  assign rst_req = rcnt_q != 3'd0;

  always_comb begin
    for (int b = 0; b < BEW; b++) bmask[b*8 +: 8] = {8{bus_be[b]}};
    wmask = bmask & FMASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_q  <= FMASK;
      halt_q <= 1'b1;
      ien_q  <= 1'b0;
      nrb_q  <= 1'b0;
    end else begin
      if (wr_tmo) tmo_q <= (tmo_q & ~wmask) | (bus_wdata & wmask);
      if (wr_ctl) begin
        halt_q <= bus_wdata[0];
        ien_q  <= bus_wdata[1];
      end
      if (nrb_lock)    nrb_q <= 1'b1;
      else if (wr_ctl) nrb_q <= bus_wdata[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_to_q   <= 1'b0;
      sts_2nd_q  <= 1'b0;
      sts_boot_q <= 1'b0;
      irq_q      <= 1'b0;
      rcnt_q     <= 3'd0;
    end else begin
      sts_to_q   <= exp1 | (sts_to_q   & ~(wr_sts & bus_wdata[0]));
      sts_2nd_q  <= exp2 | (sts_2nd_q  & ~(wr_sts & bus_wdata[1]));
      sts_boot_q <= fire | (sts_boot_q & ~(wr_sts & bus_wdata[2]));
      irq_q      <= exp1 & ien_q;
      if (fire)                rcnt_q <= 3'd4;
      else if (rcnt_q != 3'd0) rcnt_q <= rcnt_q - 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= FMAX;
      pre_q   <= '0;
      stage_q <= 1'b0;
    end else if (wr_rld) begin
      cnt_q   <= eff;
      pre_q   <= '0;
      stage_q <= 1'b0;
    end else if (!halt_q) begin
      pre_q <= tick ? '0 : pre_q + PW'(1);
      if (expire) begin
        cnt_q   <= eff;
        stage_q <= ~stage_q;
      end else if (tick) begin
        cnt_q <= cnt_q - FW'(1);
      end
    end
  end

  always_comb begin
    case (bus_addr)
      AW'(0):  bus_rdata = tmo_q;
      AW'(2):  bus_rdata = DW'({nrb_eff, ien_q, halt_q});
      AW'(3):  bus_rdata = DW'({sts_boot_q, sts_2nd_q, sts_to_q});
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk #(parameter int FW = 10) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic          rst_req,
  input logic          irq_en,
  input logic          nrb_eff,
  input logic          nrb_q,
  input logic          lock,
  input logic          halt,
  input logic          reload_wr,
  input logic [FW-1:0] cnt
);
  assert_rst_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |=> rst_req ##1 rst_req ##1 rst_req ##1 !rst_req);
  assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_irq_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_en));
  assert_nrb_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> !$past(nrb_eff));
  assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halt && !reload_wr |=> $stable(cnt));
  assert_cnt_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0);
  assert_lock_sticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock) && $past(rst_n) |-> nrb_q);
endmodule

bind wdog_two_stage wdog_two_stage_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .rst_req(rst_req),
  .irq_en(ien_q), .nrb_eff(nrb_eff), .nrb_q(nrb_q), .lock(nrb_lock),
  .halt(halt_q), .reload_wr(wr_rld), .cnt(cnt_q)
);

// File: tb/sim_wdog_two_stage.sv
`timescale 1ns/1ps
module sim_wdog_two_stage;
  localparam int P = 4;
  localparam logic [1:0] A_TMO = 2'd0, A_RLD = 2'd1, A_CTL = 2'd2, A_STS = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, nrb_lock = 1'b0;
  logic [1:0] bus_addr = A_STS, bus_be = 2'b11;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic irq, rst_req;
  int cyc = 0, checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { int due; int sel; int val; string tag; } item_t;
  item_t q[$];

  wdog_two_stage #(.WIDE(1'b1), .PRESCALE(P), .AW(2)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .nrb_lock(nrb_lock), .irq(irq), .rst_req(rst_req));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int due, input int sel, input int val, input string tag);
    item_t it;
    it.due = due; it.sel = sel; it.val = val; it.tag = tag;
    q.push_back(it);
  endtask

  initial forever begin
    @(negedge clk); #1;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        int act;
        act = (q[i].sel == 0) ? int'(bus_rdata) : (q[i].sel == 1) ? int'(irq) : int'(rst_req);
        checks++;
        if (act != q[i].val) begin
          errors++;
          $display("FAIL %s cyc %0d sel %0d actual 0x%0h expected 0x%0h",
                   q[i].tag, cyc, q[i].sel, act, q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be, output int c);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1; c = cyc;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = A_STS; bus_be = 2'b11;
  endtask

  task automatic rd_chk(input logic [1:0] a, input int val, input string tag);
    bus_addr = a;
    expect_at(cyc, 0, val, tag);
    @(negedge clk);
    bus_addr = A_STS;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  initial begin
    int c, c2, h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_at(cyc, 1, 0, "R1 irq");
    expect_at(cyc, 2, 0, "R1 rst_req");
    rd_chk(A_TMO, 16'h03FF, "R1 timeout");
    rd_chk(A_CTL, 16'h0001, "R1 control");
    rd_chk(A_STS, 16'h0000, "R1 status");
    // R2 field mask and byte enables
    wr(A_TMO, 16'hFFFF, 2'b11, c); rd_chk(A_TMO, 16'h03FF, "R2 reserved");
    wr(A_TMO, 16'h0155, 2'b01, c); rd_chk(A_TMO, 16'h0355, "R2 low byte");
    wr(A_TMO, 16'hAA00, 2'b10, c); rd_chk(A_TMO, 16'h0255, "R2 high byte");
    // R3 clamp, R4 first expiry with irq, R5 second expiry
    wr(A_TMO, 16'h0001, 2'b11, c);
    wr(A_CTL, 16'h0002, 2'b11, c);
    wr(A_RLD, 16'h0000, 2'b00, c);
    expect_at(c + 8, 0, 0, "R3 before expiry");
    expect_at(c + 8, 1, 0, "R4 irq early");
    expect_at(c + 9, 0, 1, "R3 R4 first flag");
    expect_at(c + 9, 1, 1, "R4 irq pulse");
    expect_at(c + 10, 1, 0, "R4 irq one cycle");
    expect_at(c + 16, 2, 0, "R5 rst early");
    expect_at(c + 17, 0, 7, "R5 second and boot");
    for (int k = 17; k <= 20; k++) expect_at(c + k, 2, 1, "R5 rst high");
    expect_at(c + 21, 2, 0, "R5 rst length");
    wait_to(c + 22);
    wr(A_CTL, 16'h0001, 2'b11, c2);
    // R8 write-one-to-clear
    wr(A_STS, 16'h0000, 2'b11, c); rd_chk(A_STS, 7, "R8 zero keeps");
    wr(A_STS, 16'h0002, 2'b11, c); rd_chk(A_STS, 5, "R8 clear second");
    wr(A_STS, 16'h0005, 2'b11, c); rd_chk(A_STS, 0, "R8 clear rest");
    // R6 periodic reload prevents expiry; R4 no irq when disabled
    wr(A_TMO, 16'h0003, 2'b11, c);
    wr(A_CTL, 16'h0000, 2'b11, c);
    for (int k = 0; k < 4; k++) begin
      wr(A_RLD, 16'h1234, 2'b10, c);
      expect_at(c + 9, 0, 0, "R6 serviced");
      wait_to(c + 10);
    end
    wr(A_RLD, 16'h0000, 2'b01, c);
    expect_at(c + 12, 0, 0, "R6 restart early");
    expect_at(c + 13, 0, 1, "R6 restart expiry");
    expect_at(c + 13, 1, 0, "R4 irq disabled");
    wait_to(c + 14);
    wr(A_CTL, 16'h0001, 2'b11, c2);
    wr(A_STS, 16'h0001, 2'b11, c2);
    // R7 halt holds the count
    wr(A_RLD, 16'h0000, 2'b11, c);
    expect_at(c + 40, 0, 0, "R7 halted");
    wait_to(c + 41);
    wr(A_CTL, 16'h0000, 2'b11, h);
    expect_at(h + 12, 0, 0, "R7 resume early");
    expect_at(h + 13, 0, 1, "R7 resume expiry");
    wait_to(h + 14);
    wr(A_CTL, 16'h0001, 2'b11, c2);
    wr(A_STS, 16'h0007, 2'b11, c2);
    // R9 no-reboot
    wr(A_TMO, 16'h0002, 2'b11, c);
    wr(A_CTL, 16'h0006, 2'b11, c);
    wr(A_RLD, 16'h0000, 2'b11, c);
    expect_at(c + 9, 1, 1, "R9 irq still");
    expect_at(c + 17, 0, 3, "R9 no boot flag");
    for (int k = 17; k <= 21; k++) expect_at(c + k, 2, 0, "R9 rst suppressed");
    wait_to(c + 22);
    rd_chk(A_CTL, 6, "R9 control");
    wr(A_CTL, 16'h0001, 2'b11, c2);
    wr(A_STS, 16'h0007, 2'b11, c2);
    // R10 lock
    nrb_lock = 1'b1;
    wr(A_CTL, 16'h0001, 2'b11, c); rd_chk(A_CTL, 5, "R10 locked read");
    nrb_lock = 1'b0;
    rd_chk(A_CTL, 5, "R10 stored");
    wr(A_CTL, 16'h0001, 2'b11, c); rd_chk(A_CTL, 1, "R10 unlocked clear");
    // R11 reload in expiry cycle
    wr(A_CTL, 16'h0002, 2'b11, c);
    wr(A_RLD, 16'h0000, 2'b11, c);
    wait_to(c + 8);
    wr(A_RLD, 16'h0000, 2'b11, c2);
    expect_at(c2 + 1, 0, 0, "R11 no flag");
    expect_at(c2 + 1, 1, 0, "R11 no irq");
    expect_at(c2 + 8, 0, 0, "R11 restart early");
    expect_at(c2 + 9, 0, 1, "R11 restart expiry");
    expect_at(c2 + 9, 1, 1, "R11 restart irq");
    wait_to(c2 + 12);
    wr(A_CTL, 16'h0001, 2'b11, c);
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL pending %0d items actual %0d expected 0", q.size(), q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule